// File: doc/BRIEF.md
# Hot-Plug Slot Register Controller

This block holds the slot control and slot status registers of a downstream or root port that supports native hot-plug, and produces the hot-plug interrupt. Software reaches both registers through a 16-bit configuration port with per-byte enables. The device side reports a hot-add of a function-0 device and presses of the attention button. The block answers with a request to unplug the attached device and a refusal pulse for plug attempts made while the electromechanical interlock is engaged.

The interrupt is driven from a pending condition: hot-plug interrupts enabled, and at least one supported event that is both latched in status and enabled in control. A notification goes out only when that condition changes. With message signalling off, a level line follows the condition. With it on, one single-cycle message request is issued for each change.

Top module: `hp_slot_ctrl`

## Requirements
- R1: On reset the control register reads 0x01C0 when the slot is populated and 0x07C0 when it is empty. Control fields: attention indicator [7:6] is OFF, power indicator [9:8] is ON (01) or OFF (11), power control bit 10 is 0 or 1, and all enables are 0. The status register reads 0x0040 when populated and 0x0000 when empty. Presence state is status bit 6.
- R2: A control write updates only the bytes whose enable is set. Only bits 0, 3, 4, 5 and 10:6 are stored. Bits 15:12, 2 and 1 read as zero, and the interlock-control bit 11 always reads zero.
- R3: Writing 1 to control bit 11 with byte enable 1 set inverts interlock status (status bit 7).
- R4: Every control write sets command completed (status bit 4), even when it carries other effects.
- R5: Status bits 0, 3 and 4 clear when written with 1 under byte enable 0. Presence state (bit 6) and interlock status (bit 7) ignore status writes, and all other status bits read zero.
- R6: A hot-add sets presence state, presence changed (bit 3) and attention pressed (bit 0) together. While interlock status is set, a hot-add leaves status unchanged and pulses `plug_refused` for one cycle.
- R7: An attention-button pulse sets status bit 0.
- R8: A control write that leaves power control at 1 and the power indicator at 11 while presence state is set pulses `unplug_req`, clears presence state and sets presence changed. With presence state clear, the same write gives no unplug request.
- R9: With `msi_en` low, `irq_level` equals, one cycle later, the pending condition: control bit 5 set and any of status bits 0, 3, 4 set with the matching control bit 0, 3, 4. The line drops once no enabled event remains.
- R10: With `msi_en` high, `irq_level` stays low and `irq_msg` pulses for exactly one cycle after each change of the pending condition.
- R11: Raising an event that is already latched issues no new message.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| slot_populated | input | 1 | Slot occupancy, used to pick reset values |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_sel | input | 1 | Register select: 0 control, 1 status |
| cfg_be | input | 2 | Byte enables for the write |
| cfg_wdata | input | 16 | Write data |
| cfg_rdata | output | 16 | Read data of the selected register |
| hot_add | input | 1 | Function-0 device hot-add request pulse |
| btn_press | input | 1 | Attention-button pulse |
| msi_en | input | 1 | Selects message signalling instead of the level line |
| irq_level | output | 1 | Level interrupt |
| irq_msg | output | 1 | Single-cycle message request |
| unplug_req | output | 1 | Request to remove the attached device |
| plug_refused | output | 1 | Hot-add rejected because the interlock is engaged |

## Verification
The checker assumes that a hot-add never arrives in the same cycle as a power-off control write. Without that, the unplug request could appear while presence state is already set again. It also assumes that `msi_en` changes only while no write is in flight. The stimulus drives every input at the falling edge, one action per cycle. It moves `msi_en` only in idle gaps, so both assumptions always hold. Messages are counted one cycle after the event that changes the pending condition.

// File: rtl/hp_pkg.sv
package hp_pkg;
  localparam int REG_W = 16;
  // control register bit positions
  localparam int C_ABE  = 0;
  localparam int C_PDE  = 3;
  localparam int C_CCE  = 4;
  localparam int C_HPE  = 5;
  localparam int C_AIL  = 6;
  localparam int C_PIL  = 8;
  localparam int C_PWR  = 10;
  localparam int C_LCK  = 11;
  // status register bit positions
  localparam int S_ABP  = 0;
  localparam int S_PDC  = 3;
  localparam int S_CC   = 4;
  localparam int S_PDS  = 6;
  localparam int S_LCK  = 7;
  localparam logic [1:0] IND_ON  = 2'b01;
  localparam logic [1:0] IND_OFF = 2'b11;
  localparam logic [REG_W-1:0] CTL_STORE = 16'h07F9;
  localparam logic [7:0]       STS_W1C   = 8'h19;
endpackage

// File: rtl/hp_ctrl_reg.sv
module hp_ctrl_reg
  import hp_pkg::*;
#(
  parameter int W = REG_W,
  localparam int NB = W / 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          populated,
  input  logic          wr_en,
  input  logic [NB-1:0] be,
  input  logic [W-1:0]  wdata,
  output logic [W-1:0]  ctrl_q,
  output logic          lock_flip,
  output logic          pwr_off
);
  logic [W-1:0] merged;
  logic [W-1:0] rst_val;

  for (genvar b = 0; b < NB; b++) begin : g_byte
    assign merged[8*b +: 8] = be[b] ? (wdata[8*b +: 8] & CTL_STORE[8*b +: 8])
                                    : ctrl_q[8*b +: 8];
  end

  always_comb begin
    rst_val = '0;
    rst_val[C_AIL +: 2] = IND_OFF;
    rst_val[C_PIL +: 2] = populated ? IND_ON : IND_OFF;
    rst_val[C_PWR]      = ~populated;
  end

  assign lock_flip = wr_en && be[C_LCK/8] && wdata[C_LCK];
  assign pwr_off   = wr_en && merged[C_PWR] && (merged[C_PIL +: 2] == IND_OFF);

  always_ff @(posedge clk) begin
    if (rst)        ctrl_q <= rst_val;
    else if (wr_en) ctrl_q <= merged;
  end
endmodule

// File: rtl/hp_status_reg.sv
module hp_status_reg
  import hp_pkg::*;
#(
  parameter int W = REG_W
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         populated,
  input  logic         sts_wr,
  input  logic         be_lo,
  input  logic [7:0]   wdata_lo,
  input  logic         ctrl_wr,
  input  logic         lock_flip,
  input  logic         pwr_off,
  input  logic         hot_add,
  input  logic         btn_press,
  output logic [W-1:0] sts_q,
  output logic         unplug_req,
  output logic         plug_refused
);
  logic [W-1:0] nxt;
  logic         do_unplug, do_refuse;

  always_comb begin
    nxt       = sts_q;
    do_unplug = 1'b0;
    do_refuse = 1'b0;
    if (sts_wr && be_lo) nxt[7:0] = sts_q[7:0] & ~(wdata_lo & STS_W1C);
    if (lock_flip) nxt[S_LCK] = ~sts_q[S_LCK];
    if (pwr_off && sts_q[S_PDS]) begin
      do_unplug  = 1'b1;
      nxt[S_PDS] = 1'b0;
      nxt[S_PDC] = 1'b1;
    end
    if (hot_add) begin
      if (sts_q[S_LCK]) do_refuse = 1'b1;
      else begin
        nxt[S_PDS] = 1'b1;
        nxt[S_PDC] = 1'b1;
        nxt[S_ABP] = 1'b1;
      end
    end
    if (btn_press) nxt[S_ABP] = 1'b1;
    if (ctrl_wr)   nxt[S_CC]  = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sts_q        <= '0;
      sts_q[S_PDS] <= populated;
      unplug_req   <= 1'b0;
      plug_refused <= 1'b0;
    end else begin
      sts_q        <= nxt;
      unplug_req   <= do_unplug;
      plug_refused <= do_refuse;
    end
  end
endmodule

// File: rtl/hp_irq_gen.sv
module hp_irq_gen #(
  parameter int NEV = 3
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           hp_en,
  input  logic [NEV-1:0] ev_en,
  input  logic [NEV-1:0] ev_st,
  input  logic           msi_en,
  output logic           irq_level,
  output logic           irq_msg
);
  logic pend, pend_q;

  assign pend = hp_en && |(ev_en & ev_st);

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_q    <= 1'b0;
      irq_level <= 1'b0;
      irq_msg   <= 1'b0;
    end else begin
      pend_q    <= pend;
      irq_level <= pend && !msi_en;
      irq_msg   <= msi_en && (pend != pend_q);
    end
  end
endmodule

// File: rtl/hp_slot_ctrl.sv
module hp_slot_ctrl
  import hp_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        slot_populated,
  input  logic        cfg_wr,
  input  logic        cfg_sel,
  input  logic [1:0]  cfg_be,
  input  logic [15:0] cfg_wdata,
  output logic [15:0] cfg_rdata,
  input  logic        hot_add,
  input  logic        btn_press,
  input  logic        msi_en,
  output logic        irq_level,
  output logic        irq_msg,
  output logic        unplug_req,
  output logic        plug_refused
);
  logic [REG_W-1:0] ctrl_q, sts_q;
  logic             ctrl_wr, sts_wr, lock_flip, pwr_off;
  logic [2:0]       ev_en, ev_st;

  assign ctrl_wr = cfg_wr && !cfg_sel;
  assign sts_wr  = cfg_wr &&  cfg_sel;

  hp_ctrl_reg #(.W(REG_W)) u_ctrl (
    .clk(clk), .rst(rst), .populated(slot_populated),
    .wr_en(ctrl_wr), .be(cfg_be), .wdata(cfg_wdata),
    .ctrl_q(ctrl_q), .lock_flip(lock_flip), .pwr_off(pwr_off)
  );

  hp_status_reg #(.W(REG_W)) u_sts (
    .clk(clk), .rst(rst), .populated(slot_populated),
    .sts_wr(sts_wr), .be_lo(cfg_be[0]), .wdata_lo(cfg_wdata[7:0]),
    .ctrl_wr(ctrl_wr), .lock_flip(lock_flip), .pwr_off(pwr_off),
    .hot_add(hot_add), .btn_press(btn_press),
    .sts_q(sts_q), .unplug_req(unplug_req), .plug_refused(plug_refused)
  );

  assign ev_en = {ctrl_q[C_CCE], ctrl_q[C_PDE], ctrl_q[C_ABE]};
  assign ev_st = {sts_q[S_CC],   sts_q[S_PDC],  sts_q[S_ABP]};

  hp_irq_gen #(.NEV(3)) u_irq (
    .clk(clk), .rst(rst), .hp_en(ctrl_q[C_HPE]),
    .ev_en(ev_en), .ev_st(ev_st), .msi_en(msi_en),
    .irq_level(irq_level), .irq_msg(irq_msg)
  );

  assign cfg_rdata = cfg_sel ? sts_q : ctrl_q;
endmodule

// File: rtl/hp_slot_ctrl_chk.sv
module hp_slot_ctrl_chk (
  input logic       clk,
  input logic       rst,
  input logic       cfg_wr,
  input logic       cfg_sel,
  input logic       cfg_be1,
  input logic       cfg_wd11,
  input logic       msi_en,
  input logic       hpie,
  input logic [2:0] ev_en,
  input logic [2:0] ev_st,
  input logic       eis,
  input logic       pds,
  input logic       pdc,
  input logic       irq_level,
  input logic       unplug_req,
  input logic       plug_refused
);
  AST_CC_ON_CTRL_WR: assert property (@(posedge clk) disable iff (rst)
    (cfg_wr && !cfg_sel) |=> ev_st[2]);  // R4
  AST_LOCK_TOGGLE: assert property (@(posedge clk) disable iff (rst)
    (cfg_wr && !cfg_sel && cfg_be1 && cfg_wd11) |=> (eis != $past(eis)));  // R3
  AST_UNPLUG_STATE: assert property (@(posedge clk) disable iff (rst)
    unplug_req |-> (!pds && pdc));  // R8
  AST_REFUSE_LOCKED: assert property (@(posedge clk) disable iff (rst)
    plug_refused |-> $past(eis));  // R6
  AST_LEVEL_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
    !msi_en |=> (irq_level == $past(hpie && |(ev_en & ev_st))));  // R9
  AST_MSG_MODE_QUIET: assert property (@(posedge clk) disable iff (rst)
    msi_en |=> !irq_level);  // R10
endmodule

bind hp_slot_ctrl hp_slot_ctrl_chk u_chk (
  .clk(clk), .rst(rst), .cfg_wr(cfg_wr), .cfg_sel(cfg_sel),
  .cfg_be1(cfg_be[1]), .cfg_wd11(cfg_wdata[11]), .msi_en(msi_en),
  .hpie(ctrl_q[5]), .ev_en(ev_en), .ev_st(ev_st),
  .eis(sts_q[7]), .pds(sts_q[6]), .pdc(sts_q[3]),
  .irq_level(irq_level), .unplug_req(unplug_req), .plug_refused(plug_refused)
);

// File: tb/hp_slot_ctrl_tb.sv
`timescale 1ns/1ps
module hp_slot_ctrl_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        slot_populated = 1'b1;
  logic        cfg_wr = 1'b0;
  logic        cfg_sel = 1'b0;
  logic [1:0]  cfg_be = 2'b00;
  logic [15:0] cfg_wdata = 16'h0;
  logic [15:0] cfg_rdata;
  logic        hot_add = 1'b0, btn_press = 1'b0, msi_en = 1'b0;
  logic        irq_level, irq_msg, unplug_req, plug_refused;

  always #10 clk = ~clk;

  hp_slot_ctrl u_dut (
    .clk(clk), .rst(rst), .slot_populated(slot_populated),
    .cfg_wr(cfg_wr), .cfg_sel(cfg_sel), .cfg_be(cfg_be),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
    .hot_add(hot_add), .btn_press(btn_press), .msi_en(msi_en),
    .irq_level(irq_level), .irq_msg(irq_msg),
    .unplug_req(unplug_req), .plug_refused(plug_refused)
  );

  // kinds: 0 ctrl read, 1 status read, 2 irq_level, 3 irq_msg, 4 unplug_req, 5 plug_refused
  typedef struct {
    int          kind;
    logic [15:0] exp;
    string       tag;
  } item_t;

  item_t sb[$];
  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  initial begin : monitor
    forever begin
      item_t it;
      logic [15:0] act;
      wait (sb.size() != 0);
      it = sb.pop_front();
      case (it.kind)
        0, 1:    act = cfg_rdata;
        2:       act = {15'h0, irq_level};
        3:       act = {15'h0, irq_msg};
        4:       act = {15'h0, unplug_req};
        default: act = {15'h0, plug_refused};
      endcase
      n_chk++;
      if (act !== it.exp) begin
        n_bad++;
        $display("FAIL %s kind=%0d actual=0x%04h expected=0x%04h", it.tag, it.kind, act, it.exp);
      end
    end
  end

  task automatic expect_val(int kind, logic [15:0] e, string tag);
    item_t it;
    if (kind == 0) cfg_sel = 1'b0;
    if (kind == 1) cfg_sel = 1'b1;
    it.kind = kind; it.exp = e; it.tag = tag;
    #1;
    sb.push_back(it);
    #2;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(logic sel, logic [1:0] be, logic [15:0] d);
    cfg_wr = 1'b1; cfg_sel = sel; cfg_be = be; cfg_wdata = d;
    @(negedge clk);
    cfg_wr = 1'b0; cfg_be = 2'b00;
  endtask

  task automatic pulse_add();
    hot_add = 1'b1; @(negedge clk); hot_add = 1'b0;
  endtask

  task automatic pulse_btn();
    btn_press = 1'b1; @(negedge clk); btn_press = 1'b0;
  endtask

  task automatic finish_run();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog expired");
      finish_run();
    end
  end

  initial begin : driver
    idle(3);
    rst = 1'b0;
    // R1 populated reset values
    expect_val(0, 16'h01C0, "R1 ctrl populated");
    expect_val(1, 16'h0040, "R1 status populated");
    expect_val(2, 16'h0000, "R1 irq idle");
    // R2 R3 R4 full write, interlock flip, command completed
    wr(1'b0, 2'b11, 16'hFBFF);
    expect_val(0, 16'h03F9, "R2 stored bits only");
    expect_val(1, 16'h00D0, "R3 R4 lock set and cc");
    idle(1);
    expect_val(2, 16'h0001, "R9 level raised");
    // R6 refused while locked
    pulse_add();
    expect_val(5, 16'h0001, "R6 refused pulse");
    expect_val(1, 16'h00D0, "R6 status unchanged");
    // R2 low byte only
    wr(1'b0, 2'b01, 16'h0000);
    expect_val(0, 16'h0300, "R2 byte enable");
    idle(1);
    expect_val(2, 16'h0000, "R9 level dropped");
    // R5 W1C, presence and lock untouched
    wr(1'b1, 2'b11, 16'hFFFF);
    expect_val(1, 16'h00C0, "R5 w1c");
    // R3 unlock via upper byte
    wr(1'b0, 2'b10, 16'h0800);
    expect_val(0, 16'h0000, "R2 lock bit reads zero");
    expect_val(1, 16'h0050, "R3 lock cleared");
    wr(1'b1, 2'b01, 16'h0010);
    expect_val(1, 16'h0040, "R5 clear cc");
    // enables, message mode
    wr(1'b0, 2'b11, 16'h0129);
    wr(1'b1, 2'b01, 16'h0010);
    msi_en = 1'b1;
    idle(1);
    pulse_btn();
    expect_val(1, 16'h0041, "R7 button latched");
    idle(1);
    expect_val(3, 16'h0001, "R10 message pulse");
    expect_val(2, 16'h0000, "R10 level quiet");
    idle(1);
    expect_val(3, 16'h0000, "R10 single cycle");
    pulse_btn();
    idle(1);
    expect_val(3, 16'h0000, "R11 no repeat message");
    wr(1'b1, 2'b01, 16'h0001);
    expect_val(1, 16'h0040, "R5 clear button");
    idle(1);
    expect_val(3, 16'h0001, "R10 message on fall");
    idle(1);
    msi_en = 1'b0;
    idle(1);
    // R8 power off unplug
    wr(1'b0, 2'b11, 16'h0729);
    expect_val(4, 16'h0001, "R8 unplug pulse");
    expect_val(1, 16'h0018, "R8 presence dropped");
    expect_val(0, 16'h0729, "R2 readback");
    idle(1);
    expect_val(2, 16'h0001, "R9 level on presence change");
    expect_val(4, 16'h0000, "R8 unplug single");
    wr(1'b0, 2'b11, 16'h0729);
    expect_val(4, 16'h0000, "R8 empty no unplug");
    // R6 hot add when unlocked
    pulse_add();
    expect_val(1, 16'h0059, "R6 hot add events");
    expect_val(5, 16'h0000, "R6 not refused");
    wr(1'b1, 2'b11, 16'h00FF);
    expect_val(1, 16'h0040, "R5 clear all");
    idle(1);
    expect_val(2, 16'h0000, "R9 level dropped at end");
    // R1 empty reset
    slot_populated = 1'b0;
    rst = 1'b1;
    idle(2);
    rst = 1'b0;
    expect_val(0, 16'h07C0, "R1 ctrl empty");
    expect_val(1, 16'h0000, "R1 status empty");
    idle(2);
    finish_run();
  end
endmodule